// File: doc/BRIEF.md
# PCI Transaction Phase Monitor

This block watches a 64-bit-capable PCI-style parallel bus without driving it. On every rising clock edge it samples the active-low framing and handshake lines, the width-negotiation pair, the multiplexed address/data lines, the command/byte-enable lines and the upper-half parity bit. From these samples it classifies each clock as idle, address phase, completed data phase or wait cycle, and it keeps that classification on a registered phase output.

Each data phase that completes produces a one-cycle record. The record holds the captured data and byte enables, the transfer direction latched from the command, whether the transfer was 64 bits wide, whether it was the final transfer of the transaction, and a running count of completed transfers. A separate one-cycle pulse reports an even-parity violation on the upper half of the bus. The parity bit is checked one clock after the phase it protects, and only for phases that actually used the upper half.

Every output is registered, so the result for the samples taken at clock edge k is visible after edge k. Reset is synchronous and active high.

Top module: `pci_phase_mon`

## Requirements
- R1: While `rst` is sampled high, `phase` becomes idle (2'b00). `xfer_valid`, `xfer_last`, `xfer_is64`, `xfer_write`, `par64_err` and `xfer_count` become 0, `xfer_data` becomes 0 and `xfer_be` becomes all ones.
- R2: When the monitor is idle (including the clock right after a final transfer) and `frame_n` is sampled low, that clock is the address phase: `phase` becomes 2'b01 and `xfer_count` clears to 0. If `frame_n` is sampled high, `phase` stays 2'b00.
- R3: Inside a transaction, a clock on which `irdy_n` and `trdy_n` are both sampled low is a completed data phase: `phase` becomes 2'b10 and `xfer_valid` pulses for one cycle. Any other non-idle clock is a wait cycle: `phase` becomes 2'b11 and `xfer_valid` stays low.
- R4: `xfer_last` is 1 with a completion exactly when `frame_n` was sampled high on that clock. After such a completion, the next clock is classified as from idle.
- R5: Inside a transaction, a clock with `frame_n` and `irdy_n` both sampled high returns `phase` to idle (2'b00).
- R6: On a completion, `xfer_is64` is 1 only if `req64_n` and `ack64_n` were both sampled low. In that case `xfer_data` and `xfer_be` are the full `ad` and `cbe`. Otherwise `ad[31:0]` and `cbe[3:0]` are reported, with `xfer_data[63:32]` = 0 and `xfer_be[7:4]` = 4'hF. The record holds its value between completions.
- R7: `xfer_write` is latched from `cbe[0]` in the address phase (1 = write, 0 = read) and holds for the whole transaction.
- R8: `xfer_count` increments by one with each completion, so it equals the number of completions since the last address phase.
- R9: `par64_err` pulses one cycle after the clock that follows a protected phase, when the XOR of that phase's `ad[63:32]`, `cbe[7:4]` and the `par64` sampled on the following clock is 1 (even parity).
- R10: Only an address phase with `req64_n` low, or a 64-bit completion (R6), is protected. Bad parity after wait cycles, after narrow completions, or after address phases with `req64_n` high never raises `par64_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, all sampling on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | Transaction frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| req64_n | input | 1 | Master's 64-bit request, active low |
| ack64_n | input | 1 | Target's 64-bit acknowledge, active low |
| ad | input | 64 | Multiplexed address/data lines |
| cbe | input | 8 | Command / byte-enable lines, active-low enables |
| par64 | input | 1 | Even parity bit for the upper half |
| phase | output | 2 | 00 idle, 01 address, 10 data done, 11 wait |
| xfer_valid | output | 1 | One-cycle completion pulse |
| xfer_last | output | 1 | Completion was the final one of the transaction |
| xfer_is64 | output | 1 | Completion was 64 bits wide |
| xfer_write | output | 1 | Direction of the current transaction, 1 = write |
| xfer_data | output | 64 | Captured data of the latest completion |
| xfer_be | output | 8 | Captured byte enables of the latest completion |
| xfer_count | output | 16 | Completions since the last address phase |
| par64_err | output | 1 | One-cycle upper-half parity error pulse |

## Verification
Multi-phase transactions are run with wait cycles from either side, stalled by the initiator or by the target. This separates a true handshake from a half-ready clock and shows that waits before a final phase, with the frame already released, are not yet completions. Width is tested under three conditions: both sides agreeing to 64 bits, only the master requesting them, and neither. This shows the lane masking and shows that parity is armed only for upper-half phases. Back-to-back transactions check that a new address phase follows at once after a final transfer. Single wrong parity bits are placed after address, data, wait and narrow phases, and a reset is applied in mid-transaction.

// File: rtl/pci_mon_pkg.sv
package pci_mon_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_ADDR = 2'b01,
    PH_DATA = 2'b10,
    PH_WAIT = 2'b11
  } phase_e;
endpackage

// File: rtl/mon_phase_fsm.sv
module mon_phase_fsm
  import pci_mon_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             trdy_n,
  input  logic             cmd_dir,
  output phase_e           phase_q,
  output logic             done_q,
  output logic             last_q,
  output logic             dir_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             addr_hit,
  output logic             done_hit
);
  phase_e nxt;
  logic   in_txn;
  logic   both_rdy;

  // A final completion ends the transaction; the following clock is judged as from idle.
  assign in_txn   = (phase_q != PH_IDLE) && !(done_q && last_q);
  assign both_rdy = !irdy_n && !trdy_n;

  always_comb begin
    if (!in_txn)                 nxt = frame_n ? PH_IDLE : PH_ADDR;
    else if (frame_n && irdy_n)  nxt = PH_IDLE;
    else if (both_rdy)           nxt = PH_DATA;
    else                         nxt = PH_WAIT;
  end

  assign addr_hit = (nxt == PH_ADDR);
  assign done_hit = (nxt == PH_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
      last_q  <= 1'b0;
      dir_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      phase_q <= nxt;
      done_q  <= done_hit;
      last_q  <= done_hit && frame_n;
      if (addr_hit) begin
        dir_q <= cmd_dir;
        cnt_q <= '0;
      end else if (done_hit) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R7: direction does not move once the transaction is past its address phase
  assert_dir_held_R7: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_WAIT || (phase_q == PH_DATA && $past(phase_q) != PH_IDLE)) |-> $stable(dir_q));

  // R4: after a final completion only idle or a fresh address phase may follow
  assert_last_ends_R4: assert property (@(posedge clk) disable iff (rst)
    (done_q && last_q) |=> (phase_q == PH_IDLE || phase_q == PH_ADDR));
endmodule

// File: rtl/mon_xfer_capture.sv
module mon_xfer_capture #(
  parameter int DW = 64,
  localparam int BEW = DW / 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           take,
  input  logic           wide,
  input  logic [DW-1:0]  ad,
  input  logic [BEW-1:0] cbe,
  output logic [DW-1:0]  data_q,
  output logic [BEW-1:0] be_q,
  output logic           is64_q
);
  for (genvar i = 0; i < BEW; i++) begin : g_lane
    localparam bit UPPER = (i >= BEW / 2);
    always_ff @(posedge clk) begin
      if (rst) begin
        data_q[8*i +: 8] <= '0;
        be_q[i]          <= 1'b1;
      end else if (take) begin
        if (UPPER && !wide) begin
          data_q[8*i +: 8] <= '0;
          be_q[i]          <= 1'b1;
        end else begin
          data_q[8*i +: 8] <= ad[8*i +: 8];
          be_q[i]          <= cbe[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       is64_q <= 1'b0;
    else if (take) is64_q <= wide;
  end
endmodule

// File: rtl/mon_par64_chk.sv
module mon_par64_chk #(
  parameter int HW = 32,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic [HW-1:0] hi_ad,
  input  logic [BW-1:0] hi_be,
  input  logic          par64,
  output logic          err_q
);
  logic pend_q;
  logic snap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      snap_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      pend_q <= arm;
      snap_q <= ^{hi_ad, hi_be};
      err_q  <= pend_q && (snap_q ^ par64);
    end
  end

  // R10: an error pulse needs a protected phase two sampling edges earlier
  assert_err_needs_arm_R10: assert property (@(posedge clk) disable iff (rst)
    err_q |-> $past(arm, 2));
endmodule

// File: rtl/pci_phase_mon.sv
module pci_phase_mon
  import pci_mon_pkg::*;
#(
  parameter int DW    = 64,
  parameter int CNT_W = 16,
  localparam int BEW  = DW / 8,
  localparam int HW   = DW / 2,
  localparam int HB   = BEW / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             trdy_n,
  input  logic             req64_n,
  input  logic             ack64_n,
  input  logic [DW-1:0]    ad,
  input  logic [BEW-1:0]   cbe,
  input  logic             par64,
  output logic [1:0]       phase,
  output logic             xfer_valid,
  output logic             xfer_last,
  output logic             xfer_is64,
  output logic             xfer_write,
  output logic [DW-1:0]    xfer_data,
  output logic [BEW-1:0]   xfer_be,
  output logic [CNT_W-1:0] xfer_count,
  output logic             par64_err
);
  phase_e ph;
  logic   addr_hit, done_hit, wide, arm;

  assign wide = !req64_n && !ack64_n;
  assign arm  = (addr_hit && !req64_n) || (done_hit && wide);

  mon_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .cmd_dir(cbe[0]), .phase_q(ph), .done_q(xfer_valid), .last_q(xfer_last),
    .dir_q(xfer_write), .cnt_q(xfer_count), .addr_hit(addr_hit), .done_hit(done_hit)
  );

  mon_xfer_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst(rst), .take(done_hit), .wide(wide), .ad(ad), .cbe(cbe),
    .data_q(xfer_data), .be_q(xfer_be), .is64_q(xfer_is64)
  );

  mon_par64_chk #(.HW(HW), .BW(HB)) u_par (
    .clk(clk), .rst(rst), .arm(arm), .hi_ad(ad[DW-1:HW]), .hi_be(cbe[BEW-1:HB]),
    .par64(par64), .err_q(par64_err)
  );

  assign phase = ph;

  // R3: the completion pulse coincides with a data-done phase
  assert_pulse_in_data_R3: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |-> (ph == PH_DATA));

  // R8: each completion steps the count from the previous transaction state
  assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |-> (xfer_count == (($past(ph) == PH_ADDR) ? CNT_W'(1) : CNT_W'($past(xfer_count) + 1'b1))));

  // R6: a narrow record never carries upper-lane data or enables
  assert_narrow_masked_R6: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && !xfer_is64) |-> (xfer_data[DW-1:HW] == '0 && xfer_be[BEW-1:HB] == '1));

  // R2: an address phase always restarts the count
  assert_addr_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_ADDR) |-> (xfer_count == '0 && !xfer_valid));
endmodule

// File: tb/pci_phase_mon_bench.sv
module pci_phase_mon_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, req64_n = 1'b1, ack64_n = 1'b1;
  logic [63:0] ad = '0;
  logic [7:0]  cbe = '1;
  logic        par64 = 1'b0;
  logic [1:0]  phase;
  logic        xfer_valid, xfer_last, xfer_is64, xfer_write, par64_err;
  logic [63:0] xfer_data;
  logic [7:0]  xfer_be;
  logic [15:0] xfer_count;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  pci_phase_mon u_pci_phase_mon (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .req64_n(req64_n), .ack64_n(ack64_n), .ad(ad), .cbe(cbe), .par64(par64),
    .phase(phase), .xfer_valid(xfer_valid), .xfer_last(xfer_last), .xfer_is64(xfer_is64),
    .xfer_write(xfer_write), .xfer_data(xfer_data), .xfer_be(xfer_be),
    .xfer_count(xfer_count), .par64_err(par64_err)
  );

  // Behavioural reference model
  int          m_phase;
  bit          m_valid, m_last, m_is64, m_write, m_err, m_pend, m_ppar;
  bit [63:0]   m_data;
  bit [7:0]    m_be;
  int          m_cnt;
  bit          busy, hs, wide;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_valid = 0; m_last = 0; m_is64 = 0; m_write = 0;
      m_data = '0; m_be = '1; m_cnt = 0; m_err = 0; m_pend = 0; m_ppar = 0;
    end else begin
      busy = (m_phase != 0) && !(m_valid && m_last);
      hs   = !irdy_n && !trdy_n;
      wide = !req64_n && !ack64_n;
      m_err = m_pend && (m_ppar != par64);
      m_pend = 0; m_valid = 0; m_last = 0;
      if (!busy) begin
        if (!frame_n) begin
          m_phase = 1; m_cnt = 0; m_write = cbe[0]; m_pend = !req64_n;
        end else m_phase = 0;
      end else if (frame_n && irdy_n) begin
        m_phase = 0;
      end else if (hs) begin
        m_phase = 2; m_valid = 1; m_last = frame_n; m_cnt = m_cnt + 1;
        m_is64 = wide; m_pend = wide;
        m_data = wide ? ad : {32'h0, ad[31:0]};
        m_be   = wide ? cbe : {4'hF, cbe[3:0]};
      end else begin
        m_phase = 3;
      end
      m_ppar = ^{ad[63:32], cbe[7:4]};
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2/R3/R5 phase", 64'(phase), 64'(m_phase));
    chk("R3 xfer_valid", 64'(xfer_valid), 64'(m_valid));
    chk("R4 xfer_last", 64'(xfer_last), 64'(m_last));
    chk("R6 xfer_is64", 64'(xfer_is64), 64'(m_is64));
    chk("R6 xfer_data", xfer_data, m_data);
    chk("R6 xfer_be", 64'(xfer_be), 64'(m_be));
    chk("R7 xfer_write", 64'(xfer_write), 64'(m_write));
    chk("R8 xfer_count", 64'(xfer_count), 64'(m_cnt[15:0]));
    chk("R9/R10 par64_err", 64'(par64_err), 64'(m_err));
  endtask

  bit        prev_par = 0;
  bit        prev_bad = 0;
  bit [63:0] pat = 64'h0123_4567_89AB_CDEF;

  // One bus clock: compare the last edge, then drive this clock's values.
  task automatic cyc(input bit f, input bit i, input bit t, input bit rq, input bit ak,
                     input bit [63:0] d, input bit [7:0] b, input bit bad);
    @(negedge clk);
    compare_all();
    frame_n = f; irdy_n = i; trdy_n = t; req64_n = rq; ack64_n = ak;
    ad = d; cbe = b;
    par64 = prev_par ^ prev_bad;
    prev_par = ^{d[63:32], b[7:4]};
    prev_bad = bad;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(1, 1, 1, 1, 1, pat, 8'hFF, 0);
  endtask

  // bad_at: 0 corrupts address-phase parity, k corrupts data phase k, -1 none
  task automatic txn(input bit [63:0] addr, input bit [3:0] cmd, input bit r64, input bit a64,
                     input int n, input int waits, input int bad_at);
    cyc(0, 1, 1, !r64, 1, addr, {4'hA, cmd}, bad_at == 0);
    for (int k = 1; k <= n; k++) begin
      for (int w = 0; w < waits; w++) begin
        if (k == n)      cyc(1, 0, 1, !r64, !a64, pat, 8'h3C, 1);
        else if (w[0])   cyc(0, 0, 1, !r64, !a64, pat, 8'h3C, 1);
        else             cyc(0, 1, 0, !r64, !a64, pat, 8'h3C, 1);
      end
      pat = pat * 64'd6364136223846793005 + 64'd1442695040888963407;
      cyc(k == n, 0, 0, (k == n) ? 1'b1 : !r64, !a64, pat, pat[7:0], bad_at == k);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1 reset phase", 64'(phase), 64'd0);
    chk("R1 reset be", 64'(xfer_be), 64'hFF);
    chk("R1 reset count", 64'(xfer_count), 64'd0);
    rst = 1'b0;
    idle(3);
    // R3 R7 R8: narrow write, three phases, stalls from both sides
    txn(64'h0000_0000_1000_0040, 4'h7, 0, 0, 3, 2, -1);
    idle(2);
    // R6 R9: 64-bit read, corrupted parity on data phase 2
    txn(64'hDEAD_BEEF_2000_0000, 4'h6, 1, 1, 3, 1, 2);
    idle(1);
    // R9: 64-bit address phase with bad parity
    txn(64'h1234_5678_0000_0100, 4'h6, 1, 1, 2, 0, 0);
    idle(1);
    // R10: master asks for 64 bits but target refuses; bad parity must be ignored
    txn(64'h0000_0000_3000_0000, 4'h7, 1, 0, 2, 1, 1);
    // R4 R2: back-to-back single-phase transactions, no idle between
    txn(64'h0000_0000_4000_0000, 4'h7, 0, 0, 1, 0, -1);
    txn(64'h0000_0000_5000_0000, 4'h6, 1, 1, 1, 2, 1);
    idle(1);
    // R10: narrow address phase with bad parity is ignored
    txn(64'hFFFF_0000_6000_0000, 4'h7, 0, 0, 2, 0, 0);
    idle(1);
    // R5: a transaction abandoned while waiting drops straight to idle
    cyc(0, 1, 1, 1, 1, 64'h70, 8'hF7, 0);
    cyc(0, 1, 1, 1, 1, pat, 8'h0F, 0);
    idle(2);
    // R1: reset in mid-transaction
    txn(64'h8000_0000_0000_0000, 4'h6, 1, 1, 2, 1, -1);
    cyc(0, 1, 0, 0, 0, pat, 8'h00, 0);
    rst = 1'b1;
    cyc(0, 0, 0, 0, 0, pat, 8'h00, 0);
    rst = 1'b0;
    idle(2);
    txn(64'h0000_0000_9000_0000, 4'h7, 1, 1, 4, 3, 4);
    idle(3);
    @(negedge clk);
    compare_all();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule